// File: doc/BRIEF.md
# Signed-Displacement Address Adder

This block adds a signed 8-bit displacement to a 16-bit base value. A processor datapath uses it for three jobs: forming a relative branch target from the program counter, adjusting the stack pointer by a small signed amount, and forming a 16-bit register value as the stack pointer plus a displacement. The displacement is sign-extended and added to the base, and the sum wraps around modulo 65536.

The requester selects one of these jobs with a 2-bit mode code. In branch mode the flags are left alone. In the two stack-pointer modes the block produces a full flag set. Zero and subtract are always cleared. Half-carry and carry come from the low byte of the addition. A flag-write enable tells the register file whether to take the flag set.

A registered wrapper captures the sum, flags, write enable and the cycle cost of the requesting operation one clock after a request. It holds them until the next request arrives.

Top module: `ofs_addr_adder`

## Requirements
- R1: The result sum equals the base plus the sign-extended displacement, modulo 65536, in every mode.
- R2: Mode code 0 (branch) and mode code 3 (reserved, handled like branch) drive the flag-write enable low and the flag field to 0000.
- R3: Mode code 1 (stack adjust) and mode code 2 (register form) drive the flag-write enable high and force Z (flag bit 3) and N (flag bit 2) to 0, even when the sum is zero.
- R4: In flag modes, H (flag bit 1) is the carry out of bit 3 of base[3:0] + disp[3:0], and C (flag bit 0) is the carry out of bit 7 of base[7:0] + disp, with both operands taken as unsigned.
- R5: The cost output is 16 for mode 1, 12 for mode 2, and the JUMP_COST parameter (default 12) for modes 0 and 3.
- R6: A request sampled with req_valid high at a rising edge appears on the result outputs after that edge, and res_valid is high for exactly the cycles that follow a sampled request.
- R7: When req_valid is low, the sum, flags, write enable and cost keep their previous values.
- R8: While rst_n is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe; captures the operands at the rising edge |
| req_mode | input | 2 | 0 branch, 1 stack adjust, 2 register form, 3 reserved |
| req_base | input | 16 | 16-bit base operand |
| req_disp | input | 8 | Two's-complement displacement |
| res_valid | output | 1 | High for the cycle after a captured request |
| res_sum | output | 16 | Wrapped sum |
| res_flags | output | 4 | {Z, N, H, C} |
| res_flag_we | output | 1 | Flag-write enable |
| res_cost | output | 5 | Cycle cost of the requesting operation |

## Verification
Every result is due one rising edge after the request is sampled, because exactly one register stage sits between the inputs and the outputs. The bench drives a request on a falling edge and lets one rising edge pass. It then samples every output on the next falling edge, so it never looks at a value in the same edge it changes. It then drops the strobe and samples again one full cycle later to confirm that the results hold and that res_valid falls. Operand cases include negative displacements, wrap-around past 0xFFFF and 0x0000, and a zero sum in a flag mode.

// File: rtl/ofs_addr_adder_pkg.sv
package ofs_addr_adder_pkg;

  typedef enum logic [1:0] {
    MODE_BRANCH  = 2'd0,
    MODE_SP_ADJ  = 2'd1,
    MODE_REG_SUM = 2'd2,
    MODE_RSVD    = 2'd3
  } ofs_mode_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } ofs_flags_t;

  function automatic logic mode_sets_flags(input ofs_mode_e m);
    return (m == MODE_SP_ADJ) || (m == MODE_REG_SUM);
  endfunction

endpackage

// File: rtl/ofs_sext_add.sv
module ofs_sext_add #(
  parameter int ADDR_W = 16,
  parameter int DISP_W = 8
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [ADDR_W-1:0] sum_o
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_ext;

  always_comb begin
    disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
    sum_o    = base_i + disp_ext;
  end

endmodule

// File: rtl/ofs_flag_gen.sv
module ofs_flag_gen
  import ofs_addr_adder_pkg::*;
#(
  parameter int DISP_W = 8
) (
  input  logic [DISP_W-1:0] base_lo_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic              flag_en_i,
  output ofs_flags_t        flags_o,
  output logic              we_o
);
  localparam int HALF_POS = DISP_W / 2;

  logic [DISP_W:0] carry;

  assign carry[0] = 1'b0;

  for (genvar i = 0; i < DISP_W; i++) begin : g_carry
    assign carry[i+1] = (base_lo_i[i] & disp_i[i]) |
                        (carry[i] & (base_lo_i[i] ^ disp_i[i]));
  end

  always_comb begin
    flags_o = '0;
    we_o    = flag_en_i;
    if (flag_en_i) begin
      flags_o.z = 1'b0;
      flags_o.n = 1'b0;
      flags_o.h = carry[HALF_POS];
      flags_o.c = carry[DISP_W];
    end
  end

endmodule

// File: rtl/ofs_cost_sel.sv
module ofs_cost_sel
  import ofs_addr_adder_pkg::*;
#(
  parameter int COST_W       = 5,
  parameter int SP_ADJ_COST  = 16,
  parameter int REG_SUM_COST = 12,
  parameter int JUMP_COST    = 12
) (
  input  ofs_mode_e         mode_i,
  output logic [COST_W-1:0] cost_o
);
  always_comb begin
    unique case (mode_i)
      MODE_SP_ADJ:  cost_o = COST_W'(SP_ADJ_COST);
      MODE_REG_SUM: cost_o = COST_W'(REG_SUM_COST);
      default:      cost_o = COST_W'(JUMP_COST);
    endcase
  end

endmodule

// File: rtl/ofs_addr_adder.sv
module ofs_addr_adder
  import ofs_addr_adder_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DISP_W       = 8,
  parameter int COST_W       = 5,
  parameter int SP_ADJ_COST  = 16,
  parameter int REG_SUM_COST = 12,
  parameter int JUMP_COST    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_mode,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [DISP_W-1:0] req_disp,
  output logic              res_valid,
  output logic [ADDR_W-1:0] res_sum,
  output logic [3:0]        res_flags,
  output logic              res_flag_we,
  output logic [COST_W-1:0] res_cost
);
  ofs_mode_e         mode;
  logic              flag_en;
  logic [ADDR_W-1:0] sum_c;
  ofs_flags_t        flags_c;
  logic              we_c;
  logic [COST_W-1:0] cost_c;

  assign mode    = ofs_mode_e'(req_mode);
  assign flag_en = mode_sets_flags(mode);

  ofs_sext_add #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_add (
    .base_i (req_base),
    .disp_i (req_disp),
    .sum_o  (sum_c)
  );

  ofs_flag_gen #(.DISP_W(DISP_W)) u_flags (
    .base_lo_i (req_base[DISP_W-1:0]),
    .disp_i    (req_disp),
    .flag_en_i (flag_en),
    .flags_o   (flags_c),
    .we_o      (we_c)
  );

  ofs_cost_sel #(
    .COST_W(COST_W), .SP_ADJ_COST(SP_ADJ_COST),
    .REG_SUM_COST(REG_SUM_COST), .JUMP_COST(JUMP_COST)
  ) u_cost (
    .mode_i (mode),
    .cost_o (cost_c)
  );

  // next-state
  logic              valid_d;
  logic [ADDR_W-1:0] sum_d;
  ofs_flags_t        flags_d;
  logic              we_d;
  logic [COST_W-1:0] cost_d;
  ofs_flags_t        flags_q;

  always_comb begin
    valid_d = req_valid;
    sum_d   = res_sum;
    flags_d = flags_q;
    we_d    = res_flag_we;
    cost_d  = res_cost;
    if (req_valid) begin
      sum_d   = sum_c;
      flags_d = flags_c;
      we_d    = we_c;
      cost_d  = cost_c;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_sum     <= '0;
      flags_q     <= '0;
      res_flag_we <= 1'b0;
      res_cost    <= '0;
    end else begin
      res_valid   <= valid_d;
      res_sum     <= sum_d;
      flags_q     <= flags_d;
      res_flag_we <= we_d;
      res_cost    <= cost_d;
    end
  end

  assign res_flags = flags_q;

  // R3: flag modes never set Z or N
  a_r3_zn_clear: assert property (@(posedge clk) disable iff (!rst_n)
    res_flag_we |-> (res_flags[3:2] == 2'b00));

  // R2: without a flag write the flag field stays zero
  a_r2_quiet_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !res_flag_we |-> (res_flags == 4'b0000));

  // R6: a sampled request yields a valid result next cycle
  a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);

  // R7: results hold across idle cycles
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(res_sum) && $stable(res_flags) && $stable(res_cost)));

  // R5: a flag-writing result always carries one of the two stack costs
  a_r5_flag_cost: assert property (@(posedge clk) disable iff (!rst_n)
    res_flag_we |-> (res_cost == COST_W'(SP_ADJ_COST) || res_cost == COST_W'(REG_SUM_COST)));

endmodule

// File: tb/ofs_addr_adder_tb_top.sv
module ofs_addr_adder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_mode;
  logic [15:0] req_base;
  logic [7:0]  req_disp;
  logic        res_valid;
  logic [15:0] res_sum;
  logic [3:0]  res_flags;
  logic        res_flag_we;
  logic [4:0]  res_cost;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ofs_addr_adder dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_base(req_base), .req_disp(req_disp), .res_valid(res_valid),
    .res_sum(res_sum), .res_flags(res_flags), .res_flag_we(res_flag_we),
    .res_cost(res_cost)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_sum(input logic [15:0] b, input logic [7:0] d);
    int s;
    s = int'(b) + int'($signed(d));
    return 16'(s);
  endfunction

  // Drive one request and check results one edge later (R1..R6)
  task automatic run_req(input string tag, input logic [1:0] m,
                         input logic [15:0] b, input logic [7:0] d);
    logic fl;
    logic h, c;
    logic [4:0] cost;
    fl   = (m == 2'd1) || (m == 2'd2);
    h    = ((b[3:0] + {1'b0, d[3:0]}) > 5'd15);
    c    = ((9'(b[7:0]) + 9'(d)) > 9'd255);
    cost = (m == 2'd1) ? 5'd16 : 5'd12;
    @(negedge clk);
    req_valid = 1'b1; req_mode = m; req_base = b; req_disp = d;
    @(negedge clk);
    req_valid = 1'b0;
    check("R1", {tag, " sum"}, 32'(res_sum), 32'(exp_sum(b, d)));
    check("R6", {tag, " valid"}, 32'(res_valid), 32'd1);
    check("R5", {tag, " cost"}, 32'(res_cost), 32'(cost));
    if (fl) begin
      check("R3", {tag, " we"}, 32'(res_flag_we), 32'd1);
      check("R4", {tag, " flags"}, 32'(res_flags), 32'({2'b00, h, c}));
    end else begin
      check("R2", {tag, " we"}, 32'(res_flag_we), 32'd0);
      check("R2", {tag, " flags"}, 32'(res_flags), 32'd0);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_mode = 2'd0; req_base = '0; req_disp = '0;
    repeat (2) @(negedge clk);
    check("R8", "valid", 32'(res_valid), 0);
    check("R8", "sum", 32'(res_sum), 0);
    check("R8", "flags", 32'(res_flags), 0);
    check("R8", "we", 32'(res_flag_we), 0);
    check("R8", "cost", 32'(res_cost), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_branch();
    run_req("branch fwd", 2'd0, 16'h1234, 8'h05);
    run_req("branch back", 2'd0, 16'h1234, 8'h80);
    run_req("branch wrap", 2'd0, 16'h0000, 8'hFF);
    run_req("reserved", 2'd3, 16'h00FF, 8'h01);
  endtask

  task automatic t_flag_modes();
    run_req("sp carry", 2'd1, 16'h00FF, 8'h01);
    run_req("sp neg", 2'd1, 16'h1000, 8'hFF);
    run_req("sp neg carry", 2'd1, 16'h20F8, 8'hFC);
    run_req("reg zero", 2'd2, 16'hFFF8, 8'h08);
    run_req("reg half", 2'd2, 16'h0008, 8'h08);
    run_req("reg none", 2'd2, 16'hFF10, 8'h21);
  endtask

  task automatic t_hold();
    run_req("pre hold", 2'd1, 16'h7FFF, 8'h7F);
    req_base = 16'h0001; req_disp = 8'h01; req_mode = 2'd0;
    @(negedge clk);
    check("R6", "valid drops", 32'(res_valid), 0);
    check("R7", "sum held", 32'(res_sum), 32'(exp_sum(16'h7FFF, 8'h7F)));
    check("R7", "flags held", 32'(res_flags), 32'b0011);
    check("R7", "cost held", 32'(res_cost), 16);
    check("R7", "we held", 32'(res_flag_we), 1);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    req_valid = 1'b1; req_mode = 2'd1; req_base = 16'h0100; req_disp = 8'hF0;
    @(negedge clk);
    check("R6", "b2b first", 32'(res_sum), 32'h00F0);
    req_mode = 2'd0; req_base = 16'hFFFE; req_disp = 8'h03;
    @(negedge clk);
    req_valid = 1'b0;
    check("R6", "b2b second sum", 32'(res_sum), 32'h0001);
    check("R6", "b2b second valid", 32'(res_valid), 1);
    check("R2", "b2b second we", 32'(res_flag_we), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    t_reset();
    t_branch();
    t_flag_modes();
    t_hold();
    t_back_to_back();
    finish_run();
  end

endmodule